// File: doc/BRIEF.md
# Restart Sequencer with Oscillator Settling Delay

This block decides when a small processor core may leave reset and records why it last restarted. It takes a power-on pulse, an external reset pin, a watchdog time-out pulse, a halt indicator from the core and a wake-up event. From these it drives one run enable and two status flags: `to_o` (a watchdog time-out caused the restart) and `pd_o` (the core was in power-down, meaning halt, when it restarted).

Some restart causes need a fixed settling delay for the oscillator before the core may run again: power-up, and any wake-up from halt. A plain pin reset while the core runs needs no delay and ends as soon as the pin is released. A watchdog time-out while running holds the core for a single cycle. A new cause that arrives while a delay runs starts the count again from zero. Software may clear both flags through a synchronous clear input.

Top module: `restart_seq`

## Requirements
- R1: After `rst_ni` is released, or on the clock edge that samples `por_i` high, `run_o` stays low for exactly `DLY_CYCLES` clock edges and then rises. Both flags read 0.
- R2: While the core runs and is not halted, `pin_rst_i` high forces `run_o` low on the next edge. `run_o` rises on the first edge that samples the pin low again. Both flags keep their values.
- R3: A pin reset sampled while `halt_i` is high and the core runs sets `to_o`=0 and `pd_o`=1. `run_o` rises `DLY_CYCLES` edges after the first edge that samples the pin low.
- R4: A watchdog pulse while the core runs and is not halted sets `to_o`=1 and leaves `pd_o` unchanged. It drops `run_o` for exactly one cycle.
- R5: A watchdog pulse while the core runs with `halt_i` high sets `to_o`=1 and `pd_o`=1. `run_o` rises `DLY_CYCLES` edges after the pulse.
- R6: A `wake_i` pulse while the core runs with `halt_i` high starts the settling delay and leaves the flags unchanged. With `halt_i` low, `wake_i` has no effect.
- R7: Any power-on, watchdog or pin reset that arrives during the settling delay restarts the count. For a pin reset, the full delay then follows the pin's release.
- R8: `flag_clr_i` clears both flags on the next edge. A flag write by a restart cause in the same cycle takes precedence.
- R9: When causes coincide, the order of priority is power-on, then pin reset, then watchdog, then wake-up. A lower-priority cause in the same cycle is ignored.
- R10: `halt_i` is only taken into account while `run_o` is high. During a delay or a reset hold, a halted wake-up or watchdog behaves as if the core were not halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, treated as power-up |
| por_i | input | 1 | Synchronous power-on restart pulse |
| pin_rst_i | input | 1 | External reset pin level, active high |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| halt_i | input | 1 | Core is in the halt state |
| wake_i | input | 1 | Wake-up event from halt |
| flag_clr_i | input | 1 | Synchronous clear of both status flags |
| run_o | output | 1 | Core run enable |
| to_o | output | 1 | Watchdog time-out status flag |
| pd_o | output | 1 | Power-down (halt) status flag |

## Verification
The bench measures the exact number of low cycles after each cause. It does this because an off-by-one in the counter, or a delay wrongly applied to a running pin reset, would change those counts. It fires watchdog and pin resets in the middle of a delay, and a design that did not restart the count would release the core early. It drives coinciding causes, a clear that collides with a watchdog, and halted-style wake-ups during a delay. A design with the wrong priority would corrupt the flags or restart the delay. A design that honoured `halt_i` outside the running state would set `pd_o` or extend the hold.

// File: rtl/restart_pkg.sv
package restart_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DELAY = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rs_cause_dec.sv
module rs_cause_dec (
  input  logic por_i,
  input  logic pin_i,
  input  logic wdt_i,
  input  logic wake_i,
  input  logic halt_i,
  input  logic running_i,
  output logic halted_o,
  output logic ev_por_o,
  output logic ev_pin_o,
  output logic ev_wdt_o,
  output logic ev_wake_o
);
  // halt is meaningful only while the core runs (R10)
  assign halted_o  = halt_i & running_i;
  // fixed priority: por > pin > wdt > wake (R9)
  assign ev_por_o  = por_i;
  assign ev_pin_o  = pin_i & ~por_i;
  assign ev_wdt_o  = wdt_i & ~pin_i & ~por_i;
  assign ev_wake_o = wake_i & halted_o & ~wdt_i & ~pin_i & ~por_i;
endmodule

// File: rtl/rs_delay_cnt.sv
module rs_delay_cnt #(
  parameter int DLY_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CNT_W = (DLY_CYCLES > 1) ? $clog2(DLY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DLY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  assert_cnt_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_clr_restarts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rs_status.sv
module rs_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_por_i,
  input  logic ev_pin_i,
  input  logic ev_wdt_i,
  input  logic halted_i,
  input  logic clr_i,
  output logic to_o,
  output logic pd_o
);
  logic to_q, pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_q <= 1'b0;
      pd_q <= 1'b0;
    end else if (ev_por_i) begin
      to_q <= 1'b0;
      pd_q <= 1'b0;
    end else if (ev_pin_i && halted_i) begin
      to_q <= 1'b0;
      pd_q <= 1'b1;
    end else if (ev_wdt_i) begin
      to_q <= 1'b1;
      pd_q <= pd_q | halted_i;
    end else if (clr_i) begin
      to_q <= 1'b0;
      pd_q <= 1'b0;
    end
  end

  assign to_o = to_q;
  assign pd_o = pd_q;

  assert_por_flags_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_por_i |=> (!to_o && !pd_o));
  assert_wdt_sets_to_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_wdt_i |=> to_o);
  assert_pd_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_o) |-> $past(ev_por_i || clr_i));
  assert_pin_run_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_pin_i && !halted_i && !clr_i) |=> ($stable(to_o) && $stable(pd_o)));
endmodule

// File: rtl/restart_seq.sv
module restart_seq
  import restart_pkg::*;
#(
  parameter int DLY_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  input  logic pin_rst_i,
  input  logic wdt_to_i,
  input  logic halt_i,
  input  logic wake_i,
  input  logic flag_clr_i,
  output logic run_o,
  output logic to_o,
  output logic pd_o
);
  rs_state_e state_q, state_n;
  logic      need_q, need_n;
  logic      dly_start, dly_done, in_dly, running;
  logic      halted, ev_por, ev_pin, ev_wdt, ev_wake;

  assign running = (state_q == ST_RUN);
  assign in_dly  = (state_q == ST_DELAY);

  rs_cause_dec u_dec (
    .por_i     (por_i),
    .pin_i     (pin_rst_i),
    .wdt_i     (wdt_to_i),
    .wake_i    (wake_i),
    .halt_i    (halt_i),
    .running_i (running),
    .halted_o  (halted),
    .ev_por_o  (ev_por),
    .ev_pin_o  (ev_pin),
    .ev_wdt_o  (ev_wdt),
    .ev_wake_o (ev_wake)
  );

  always_comb begin
    state_n   = state_q;
    need_n    = need_q;
    dly_start = 1'b0;
    if (ev_por) begin
      state_n   = ST_DELAY;
      dly_start = 1'b1;
      need_n    = 1'b0;
    end else if (ev_pin) begin
      // remember whether release must be followed by the settling delay
      state_n = ST_HOLD;
      need_n  = halted | in_dly | ((state_q == ST_HOLD) & need_q);
    end else if (ev_wdt) begin
      if (halted || in_dly) begin
        state_n   = ST_DELAY;
        dly_start = 1'b1;
        need_n    = 1'b0;
      end else begin
        state_n = ST_HOLD;
        need_n  = (state_q == ST_HOLD) & need_q;
      end
    end else if (ev_wake) begin
      state_n   = ST_DELAY;
      dly_start = 1'b1;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (need_q) begin
            state_n   = ST_DELAY;
            dly_start = 1'b1;
            need_n    = 1'b0;
          end else begin
            state_n = ST_RUN;
          end
        end
        ST_DELAY: if (dly_done) state_n = ST_RUN;
        default:  state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DELAY;
      need_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      need_q  <= need_n;
    end
  end

  rs_delay_cnt #(.DLY_CYCLES(DLY_CYCLES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (dly_start),
    .en_i   (in_dly & ~dly_done),
    .done_o (dly_done)
  );

  rs_status u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_por_i (ev_por),
    .ev_pin_i (ev_pin),
    .ev_wdt_i (ev_wdt),
    .halted_i (halted),
    .clr_i    (flag_clr_i),
    .to_o     (to_o),
    .pd_o     (pd_o)
  );

  assign run_o = running;

  assert_pin_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_rst_i |=> !run_o);
  assert_run_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past((state_q == ST_HOLD && !need_q) || dly_done));
  assert_wake_delay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_wake |=> !run_o);
  assert_por_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (!run_o && state_q == ST_DELAY));
endmodule

// File: tb/restart_seq_tb.sv
module restart_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 1024;
  localparam int WDOG = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por_i = 0, pin_rst_i = 0, wdt_to_i = 0, halt_i = 0, wake_i = 0, flag_clr_i = 0;
  logic run_o, to_o, pd_o;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  restart_seq #(.DLY_CYCLES(DLY)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por_i), .pin_rst_i(pin_rst_i),
    .wdt_to_i(wdt_to_i), .halt_i(halt_i), .wake_i(wake_i), .flag_clr_i(flag_clr_i),
    .run_o(run_o), .to_o(to_o), .pd_o(pd_o)
  );

  // behavioural reference: remaining-cycle counter and pending-delay marker
  bit m_run, m_hold, m_need, m_to, m_pd;
  int m_left;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_hold = 0; m_need = 0; m_to = 0; m_pd = 0; m_left = DLY;
    end else begin
      bit h, dl, wr;
      h  = halt_i && m_run;
      dl = !m_run && !m_hold;
      wr = por_i || (pin_rst_i && h) || (!pin_rst_i && wdt_to_i);
      if (por_i) begin m_to = 0; m_pd = 0; end
      else if (pin_rst_i) begin if (h) begin m_to = 0; m_pd = 1; end end
      else if (wdt_to_i) begin m_to = 1; if (h) m_pd = 1; end
      if (!wr && flag_clr_i) begin m_to = 0; m_pd = 0; end

      if (por_i) begin
        m_run = 0; m_hold = 0; m_need = 0; m_left = DLY;
      end else if (pin_rst_i) begin
        m_need = h || dl || (m_hold && m_need);
        m_hold = 1; m_run = 0;
      end else if (wdt_to_i) begin
        if (h || dl) begin m_run = 0; m_hold = 0; m_need = 0; m_left = DLY; end
        else begin m_need = m_hold && m_need; m_hold = 1; m_run = 0; end
      end else if (wake_i && h) begin
        m_run = 0; m_left = DLY;
      end else if (m_hold) begin
        m_hold = 0;
        if (m_need) begin m_need = 0; m_left = DLY; end
        else m_run = 1;
      end else if (!m_run) begin
        if (m_left == 1) m_run = 1;
        else m_left--;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_ni) begin
      chk(cur_req, "model run_o", run_o, m_run);
      chk(cur_req, "model to_o", to_o, m_to);
      chk(cur_req, "model pd_o", pd_o, m_pd);
    end
    if (cycles > WDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    while (!run_o && n < DLY + 20) begin
      @(negedge clk);
      n++;
    end
    chk(req, "edges until run", n, exp);
  endtask

  task automatic pulse_por();  por_i = 1;  @(negedge clk); por_i = 0;  endtask
  task automatic pulse_wdt();  wdt_to_i = 1; @(negedge clk); wdt_to_i = 0; endtask
  task automatic pulse_wake(); wake_i = 1; @(negedge clk); wake_i = 0; endtask
  task automatic pulse_clr();  flag_clr_i = 1; @(negedge clk); flag_clr_i = 0; endtask

  initial begin
    // R1: reset state and power-up delay
    step(2);
    chk("R1", "reset run_o", run_o, 0);
    chk("R1", "reset to_o", to_o, 0);
    chk("R1", "reset pd_o", pd_o, 0);
    rst_ni = 1;
    measure("R1", DLY);

    // R4: watchdog while running
    cur_req = "R4";
    pulse_wdt();
    chk("R4", "run low after wdt", run_o, 0);
    chk("R4", "to_o", to_o, 1);
    chk("R4", "pd_o", pd_o, 0);
    measure("R4", 1);

    // R8: clear
    cur_req = "R8";
    pulse_clr();
    chk("R8", "to_o cleared", to_o, 0);

    // R6: halted wake-up
    cur_req = "R6";
    halt_i = 1;
    pulse_wake();
    halt_i = 0;
    chk("R6", "to_o kept", to_o, 0);
    chk("R6", "pd_o kept", pd_o, 0);
    measure("R6", DLY);
    pulse_wake();
    step(1);
    chk("R6", "wake not halted run_o", run_o, 1);

    // R3: pin reset from halt
    cur_req = "R3";
    halt_i = 1;
    pin_rst_i = 1;
    step(3);
    halt_i = 0;
    chk("R3", "to_o", to_o, 0);
    chk("R3", "pd_o", pd_o, 1);
    pin_rst_i = 0;
    measure("R3", DLY + 1);

    // R2: pin reset while running
    cur_req = "R2";
    pin_rst_i = 1;
    step(4);
    chk("R2", "run low while pin", run_o, 0);
    chk("R2", "pd_o unchanged", pd_o, 1);
    pin_rst_i = 0;
    measure("R2", 1);

    // R5: watchdog from halt
    cur_req = "R5";
    pulse_clr();
    halt_i = 1;
    pulse_wdt();
    halt_i = 0;
    chk("R5", "to_o", to_o, 1);
    chk("R5", "pd_o", pd_o, 1);
    measure("R5", DLY);

    // R8: clear collides with watchdog
    cur_req = "R8";
    pulse_clr();
    chk("R8", "pd_o cleared", pd_o, 0);
    wdt_to_i = 1; flag_clr_i = 1;
    @(negedge clk);
    wdt_to_i = 0; flag_clr_i = 0;
    chk("R8", "wdt wins over clr", to_o, 1);
    measure("R8", 1);

    // R7: watchdog in the middle of a delay
    cur_req = "R7";
    pulse_por();
    step(500);
    pulse_wdt();
    chk("R7", "to_o after wdt in delay", to_o, 1);
    measure("R7", DLY);

    // R7: pin during delay still gets full delay after release
    pulse_por();
    step(100);
    pin_rst_i = 1;
    step(2);
    pin_rst_i = 0;
    measure("R7", DLY + 1);

    // R9: coinciding causes
    cur_req = "R9";
    pulse_wdt();
    measure("R9", 1);
    por_i = 1; wdt_to_i = 1;
    @(negedge clk);
    por_i = 0; wdt_to_i = 0;
    chk("R9", "por beats wdt to_o", to_o, 0);
    measure("R9", DLY);
    pulse_wdt();
    measure("R9", 1);
    pin_rst_i = 1; wdt_to_i = 1; halt_i = 1;
    @(negedge clk);
    wdt_to_i = 0; halt_i = 0;
    chk("R9", "pin beats wdt to_o", to_o, 0);
    chk("R9", "pin beats wdt pd_o", pd_o, 1);
    pin_rst_i = 0;
    measure("R9", DLY + 1);

    // R10: halt ignored during delay
    cur_req = "R10";
    pulse_clr();
    pulse_por();
    step(10);
    halt_i = 1;
    pulse_wake();
    measure("R10", DLY - 11);
    halt_i = 0;
    pulse_por();
    step(10);
    halt_i = 1;
    pulse_wdt();
    halt_i = 0;
    chk("R10", "pd_o not set in delay", pd_o, 0);
    measure("R10", DLY);

    step(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule